// File: doc/BRIEF.md
# Lone-Bit Test Pattern Generator

This block emits a repeating 10-bit symbol stream for transmitter jitter and amplitude measurement. Every dword is four data characters, D12.0, D11.4, D12.0 and D11.3. Each character is 8b/10b encoded against a tracked running disparity. The last character is chosen so that every dword ends at the opposite disparity to the one it began with. Consecutive dwords therefore alternate between two fixed 40-bit encodings, and the stream always contains isolated single bits, whatever the starting disparity.

A one-cycle `start` pulse begins a run. At that pulse the block loads the initial running disparity from `init_rd_pos` and latches the length choice from `long_sel`. It then outputs one symbol per clock until the chosen number of dwords has been sent, pulses `done` and goes idle. Only the characters the pattern needs are encoded.

Top module: `lbp_gen`

## Requirements
- R1: After reset, `sym_valid` is 0, `done` is 0 and `rd_pos` is 0 (negative disparity).
- R2: On the clock edge that samples `start`=1, `rd_pos` takes the value of `init_rd_pos` (1 means positive) and `sym_valid` goes to 0. The first symbol appears with `sym_valid`=1 one cycle later.
- R3: The characters of each dword are sent in the order D12.0, D11.4, D12.0, D11.3. The bit sent first (`a`) is on `sym_o[9]` and the last (`j`) is on `sym_o[0]`. From negative disparity a dword is 0x0DB, 0x342, 0x0DB, 0x343. From positive disparity it is 0x0D4, 0x34D, 0x0D4, 0x34C.
- R4: `rd_pos` shows the disparity after the symbol shown. It inverts when the symbol has 4 or 6 ones and holds when the symbol has 5 ones.
- R5: Each dword leaves the running disparity inverted, so successive dwords alternate between the two encodings listed in R3.
- R6: A run is 128 dwords (512 symbols) when `long_sel`=0 at start, and 2048 dwords (8192 symbols) when it is 1. Changes to `long_sel` during a run have no effect.
- R7: `done` is 1 for exactly one cycle, directly after the cycle that shows the last symbol. In that cycle and afterwards `sym_valid` is 0 until the next start.
- R8: A `start` pulse during a run discards the run. The cycle after it has `sym_valid`=0, then output begins again from the first character of dword zero, using the newly selected disparity and length.
- R9: Within the first two dwords, from either starting disparity, the serial stream contains a lone one (bits 00001000) and a lone zero (bits 110110111101).
- R10: Every valid symbol has between 4 and 6 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin or restart a run |
| long_sel | input | 1 | 1 selects the long run length, sampled at start |
| init_rd_pos | input | 1 | Initial running disparity, 1 means positive, sampled at start |
| sym_o | output | 10 | Encoded symbol, first transmitted bit at bit 9 |
| sym_valid | output | 1 | `sym_o` holds a pattern symbol |
| rd_pos | output | 1 | Running disparity after the current symbol, 1 means positive |
| done | output | 1 | One-cycle pulse after the final symbol |

## Verification
A wrong disparity state shows up within one symbol. The next character comes out as its complementary encoding, so both the symbol value and `rd_pos` differ from the alternating table at once. A slipped character or dword counter first shows as a symbol out of order. Otherwise it shows as a symbol count before `done` that is not 512 or 8192, which the bench can see only when the run ends. A broken lone-bit property is caught by scanning the serial bits of the first two dwords from each starting disparity.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

   localparam int SYM_W      = 10;
   localparam int CHAR_COUNT = 4;

   typedef logic [1:0]       char_idx_t;
   typedef logic [SYM_W-1:0] sym_t;

   // Character byte for each slot of a dword (y in [7:5], x in [4:0]).
   function automatic logic [7:0] pattern_byte(input char_idx_t idx);
      logic [7:0] b;
      case (idx)
         2'd0:    b = 8'h0C;   // D12.0
         2'd1:    b = 8'h8B;   // D11.4
         2'd2:    b = 8'h0C;   // D12.0
         default: b = 8'h6B;   // D11.3, flips the dword's ending disparity
      endcase
      return b;
   endfunction

   // Six-bit sub-block (a at bit 5) for negative disparity.
   // Only the codes used by the pattern are provided.
   function automatic logic [5:0] code6_neg(input logic [4:0] x);
      logic [5:0] c;
      case (x)
         5'd11:   c = 6'b110100;
         5'd12:   c = 6'b001101;
         default: c = 6'b101010;
      endcase
      return c;
   endfunction

   // Four-bit sub-block (f at bit 3), chosen by disparity after the six-bit part.
   function automatic logic [3:0] code4(input logic rd_is_pos, input logic [2:0] y);
      logic [3:0] c;
      case ({rd_is_pos, y})
         4'b0_000: c = 4'b1011;
         4'b1_000: c = 4'b0100;
         4'b0_011: c = 4'b1100;
         4'b1_011: c = 4'b0011;
         4'b0_100: c = 4'b1101;
         4'b1_100: c = 4'b0010;
         default:  c = 4'b0101;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/lbp_sequencer.sv
module lbp_sequencer
   import lbp_pkg::*;
#(
   parameter int LONG_DWORDS  = 2048,
   parameter int SHORT_DWORDS = 128
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      start,
   input  logic      long_sel,
   output logic      adv,
   output char_idx_t ch_idx,
   output logic      last
);

   localparam int DW_W = $clog2(LONG_DWORDS + 1);
   localparam logic [DW_W-1:0] LONG_LIM  = DW_W'(LONG_DWORDS);
   localparam logic [DW_W-1:0] SHORT_LIM = DW_W'(SHORT_DWORDS);
   localparam char_idx_t       LAST_CH   = char_idx_t'(CHAR_COUNT - 1);

   logic            active_q;
   logic            long_q;
   char_idx_t       ch_q;
   logic [DW_W-1:0] dw_q;
   logic [DW_W-1:0] limit;

   assign limit  = long_q ? LONG_LIM : SHORT_LIM;
   assign last   = active_q && (ch_q == LAST_CH) && (dw_q == limit - DW_W'(1));
   assign adv    = active_q;
   assign ch_idx = ch_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         long_q   <= 1'b0;
         ch_q     <= '0;
         dw_q     <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         long_q   <= long_sel;
         ch_q     <= '0;
         dw_q     <= '0;
      end else if (active_q) begin
         ch_q <= ch_q + 2'd1;
         if (ch_q == LAST_CH) begin
            dw_q <= dw_q + DW_W'(1);
         end
         if (last) begin
            active_q <= 1'b0;
         end
      end
   end

   // The dword counter never reaches the selected length while running.
   assert_dw_in_range_R6: assert property (@(posedge clk) disable iff (rst)
      active_q |-> (dw_q < limit));

   // The final character ends the run unless a restart arrives with it.
   assert_stop_after_last_R7: assert property (@(posedge clk) disable iff (rst)
      (last && !start) |=> !active_q);

   // A restart always rewinds to the first slot of dword zero.
   assert_restart_rewind_R8: assert property (@(posedge clk) disable iff (rst)
      start |=> (active_q && ch_q == '0 && dw_q == '0));

endmodule

// File: rtl/lbp_char_coder.sv
module lbp_char_coder
   import lbp_pkg::*;
(
   input  logic       rd_in,
   input  logic [7:0] data,
   output sym_t       sym,
   output logic       rd_out
);

   logic [5:0] c6_neg;
   logic [5:0] c6;
   logic [3:0] c4;
   logic       rd_mid;
   logic       c6_neutral;
   logic       c4_neutral;

   always_comb begin
      c6_neg     = code6_neg(data[4:0]);
      c6_neutral = ($countones(c6_neg) == 3);
      c6         = (rd_in && !c6_neutral) ? ~c6_neg : c6_neg;
      rd_mid     = c6_neutral ? rd_in : ~rd_in;
      c4         = code4(rd_mid, data[7:5]);
      c4_neutral = ($countones(c4) == 2);
      rd_out     = c4_neutral ? rd_mid : ~rd_mid;
      sym        = {c6, c4};
   end

endmodule

// File: rtl/lbp_symbol_reg.sv
module lbp_symbol_reg
   import lbp_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      load,
   input  logic      load_rd,
   input  logic      adv,
   input  char_idx_t ch_idx,
   input  logic      last,
   output sym_t      sym_q,
   output logic      valid_q,
   output logic      rd_q,
   output logic      done_q
);

   sym_t next_sym;
   logic next_rd;
   logic last_q;

   lbp_char_coder u_coder (
      .rd_in  (rd_q),
      .data   (pattern_byte(ch_idx)),
      .sym    (next_sym),
      .rd_out (next_rd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sym_q   <= '0;
         valid_q <= 1'b0;
         rd_q    <= 1'b0;
         last_q  <= 1'b0;
         done_q  <= 1'b0;
      end else if (load) begin
         valid_q <= 1'b0;
         rd_q    <= load_rd;
         last_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         valid_q <= adv;
         last_q  <= adv && last;
         done_q  <= valid_q && last_q;
         if (adv) begin
            sym_q <= next_sym;
            rd_q  <= next_rd;
         end
      end
   end

   // Every emitted symbol is one of the balanced or near-balanced codes.
   assert_balance_R10: assert property (@(posedge clk) disable iff (rst)
      valid_q |-> ($countones(sym_q) >= 4 && $countones(sym_q) <= 6));

   // Disparity flips exactly when the emitted symbol is unbalanced.
   assert_rd_track_R4: assert property (@(posedge clk) disable iff (rst)
      valid_q |-> ((rd_q != $past(rd_q)) == ($countones(sym_q) != 5)));

   // A start reloads the disparity and blanks the output for a cycle.
   assert_load_rd_R2: assert property (@(posedge clk) disable iff (rst)
      load |=> (rd_q == $past(load_rd) && !valid_q));

   // The first symbol of any run carries the D12 six-bit sub-block.
   assert_first_char_R3: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !$past(valid_q)) |-> (sym_q[9:4] == 6'b001101));

   // Completion is a single-cycle pulse with no symbol beside it.
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      done_q |-> (!valid_q && !$past(done_q)));

endmodule

// File: rtl/lbp_gen.sv
module lbp_gen
   import lbp_pkg::*;
#(
   parameter int LONG_DWORDS    = 2048,
   parameter int SHORT_DWORDS   = 128,
   parameter bit FIRST_BIT_HIGH = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       long_sel,
   input  logic       init_rd_pos,
   output logic [9:0] sym_o,
   output logic       sym_valid,
   output logic       rd_pos,
   output logic       done
);

   if (SHORT_DWORDS < 1) begin : g_bad_short
      $error("lbp_gen: SHORT_DWORDS must be at least 1");
   end
   if (LONG_DWORDS < SHORT_DWORDS) begin : g_bad_long
      $error("lbp_gen: LONG_DWORDS must not be below SHORT_DWORDS");
   end
   if (SYM_W != 10) begin : g_bad_sym
      $error("lbp_gen: symbol width must be 10");
   end

   logic      adv;
   logic      last;
   char_idx_t ch_idx;
   sym_t      sym_a_high;

   lbp_sequencer #(
      .LONG_DWORDS  (LONG_DWORDS),
      .SHORT_DWORDS (SHORT_DWORDS)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .long_sel (long_sel),
      .adv      (adv),
      .ch_idx   (ch_idx),
      .last     (last)
   );

   lbp_symbol_reg u_out (
      .clk     (clk),
      .rst     (rst),
      .load    (start),
      .load_rd (init_rd_pos),
      .adv     (adv),
      .ch_idx  (ch_idx),
      .last    (last),
      .sym_q   (sym_a_high),
      .valid_q (sym_valid),
      .rd_q    (rd_pos),
      .done_q  (done)
   );

   if (FIRST_BIT_HIGH) begin : g_order_msb
      assign sym_o = sym_a_high;
   end else begin : g_order_lsb
      for (genvar i = 0; i < SYM_W; i++) begin : g_rev
         assign sym_o[i] = sym_a_high[SYM_W-1-i];
      end
   end

endmodule

// File: tb/tb_lbp_gen.sv
module tb_lbp_gen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       long_sel = 1'b0;
   logic       init_rd_pos = 1'b0;
   logic [9:0] sym_o;
   logic       sym_valid;
   logic       rd_pos;
   logic       done;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   lbp_gen dut (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .long_sel    (long_sel),
      .init_rd_pos (init_rd_pos),
      .sym_o       (sym_o),
      .sym_valid   (sym_valid),
      .rd_pos      (rd_pos),
      .done        (done)
   );

   // {symbol, disparity after}: entries 0..3 from negative, 4..7 from positive.
   localparam logic [10:0] VEC [0:7] = '{
      {10'h0DB, 1'b1}, {10'h342, 1'b0}, {10'h0DB, 1'b1}, {10'h343, 1'b1},
      {10'h0D4, 1'b0}, {10'h34D, 1'b1}, {10'h0D4, 1'b0}, {10'h34C, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Drive a one-cycle start; returns at the negedge after the sampling edge.
   task automatic pulse_start(input logic lng, input logic rdp);
      @(negedge clk);
      start       = 1'b1;
      long_sel    = lng;
      init_rd_pos = rdp;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Walk the vector table over two dwords and scan for the lone bits.
   task automatic walk(input logic rdp);
      logic [15:0] sh = '0;
      bit saw_one = 0;
      bit saw_zero = 0;
      pulse_start(1'b0, rdp);
      chk(rd_pos == rdp && !sym_valid, "R2 load", {rd_pos, sym_valid}, {rdp, 1'b0});
      for (int k = 0; k < 8; k++) begin
         int idx;
         idx = ((((k / 4) % 2) ^ int'(rdp)) * 4) + (k % 4);
         @(negedge clk);
         chk(sym_valid == 1'b1, "R3 valid", sym_valid, 1);
         chk(sym_o == VEC[idx][10:1], "R3/R5 symbol", sym_o, VEC[idx][10:1]);
         chk(rd_pos == VEC[idx][0], "R4/R5 disparity", rd_pos, VEC[idx][0]);
         for (int b = 9; b >= 0; b--) begin
            sh = {sh[14:0], sym_o[b]};
            if (sh[7:0] == 8'b00001000) saw_one = 1;
            if (sh[11:0] == 12'b110110111101) saw_zero = 1;
         end
      end
      chk(saw_one, "R9 lone one", saw_one, 1);
      chk(saw_zero, "R9 lone zero", saw_zero, 1);
   endtask

   // Count symbols until done; optionally flip long_sel mid-run.
   task automatic count_run(input int already, input int exp_syms, input bit flip, input string req);
      int  cnt = already;
      bit  prev_valid = 1'b1;
      bit  got_done = 0;
      for (int c = 0; c < 10000; c++) begin
         @(negedge clk);
         if (done) begin
            got_done = 1;
            chk(!sym_valid && prev_valid, "R7 done timing", {sym_valid, prev_valid}, 2'b01);
            break;
         end
         if (sym_valid) cnt++;
         if (cnt == 3 && flip) long_sel = ~long_sel;
         prev_valid = sym_valid;
      end
      chk(got_done, "R7 done seen", got_done, 1);
      chk(cnt == exp_syms, req, cnt, exp_syms);
      @(negedge clk);
      chk(!done && !sym_valid, "R7 single pulse and idle", {done, sym_valid}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(!sym_valid && !done && !rd_pos, "R1 reset", {sym_valid, done, rd_pos}, 0);

      // Table walk from both starting disparities (R3, R4, R5, R9)
      walk(1'b0);
      walk(1'b1);

      // R6 short length
      pulse_start(1'b0, 1'b0);
      count_run(0, 512, 1'b0, "R6 short length");
      // R6 long length
      pulse_start(1'b1, 1'b1);
      count_run(0, 8192, 1'b0, "R6 long length");
      // R6 length select change during run is ignored
      pulse_start(1'b0, 1'b1);
      count_run(0, 512, 1'b1, "R6 mid-run long_sel ignored");

      // R8 restart mid-pattern
      pulse_start(1'b0, 1'b1);
      repeat (6) @(negedge clk);
      pulse_start(1'b0, 1'b0);
      chk(!sym_valid && rd_pos == 1'b0, "R8 restart blank", {sym_valid, rd_pos}, 0);
      @(negedge clk);
      chk(sym_valid && sym_o == 10'h0DB, "R8 restart first symbol", sym_o, 10'h0DB);
      chk(rd_pos == 1'b1, "R8 restart disparity", rd_pos, 1);
      count_run(1, 512, 1'b0, "R8 restart full length");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule